// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block pairs an asynchronous serial transmitter with a receiver. Both run from a shared 16x oversampling baud tick. A small set of static control inputs selects the frame length (10 or 11 bits), parity on or off, even or odd parity, and one of two idle-line detection styles. The same inputs also select a loopback test path and an open-drain drive style for the serial output. A parallel word is loaded with a one-cycle strobe and shifted out least significant bit first. Incoming frames are sampled at mid-bit and returned as a parallel word, together with parity and framing error flags.

Idle-line detection flags a full frame time of continuous high line. In the short style, counting starts at any high bit, even one inside a character. In the long style, counting starts only after the stop bit of a received frame. The flag pulses once per idle period and re-arms only after the line has been seen low.

In loopback the transmitter output feeds the receiver internally while the external serial output rests high. Loopback takes effect only when both the transmitter and the receiver are enabled.

Top module: `sci_xcvr`

## Requirements
- R1: A transmitted frame is one start bit (0), then data bits least significant first, then an optional parity bit, then a stop bit (1), each lasting 16 baud ticks. `ctl_frame11`=0 gives 10 bits and 1 gives 11 bits. The data bit count is 8 or 9 without parity and 7 or 8 with parity. When not sending, the transmit line is high.
- R2: With `ctl_par_en`=1 the parity bit follows the data. `ctl_par_odd`=0 makes the count of ones over data plus parity even, and 1 makes it odd. A received parity mismatch sets `rx_par_err` with `rx_valid`. With parity off, `rx_par_err` stays 0.
- R3: The receiver qualifies the start bit at its middle and samples each later bit at mid-bit. It then pulses `rx_valid` for one cycle, with `rx_data` holding the data bits and zeros above them.
- R4: `tx_load` starts a frame only when `ctl_tx_en`=1 and no frame is in progress. A load while busy, or while disabled, is ignored. `tx_busy` is high for the whole frame.
- R5: With `ctl_idle_long`=0, the idle count starts at any high bit seen on the receive line, even one inside a character.
- R6: With `ctl_idle_long`=1, the idle count starts only after the stop bit of a received frame.
- R7: `idle_det` pulses for one cycle once a frame time (10 or 11 bit times) of continuous high has been counted. It pulses again only after a low bit has been received.
- R8: When `ctl_loop`, `ctl_tx_en` and `ctl_rx_en` are all 1, the receiver takes the transmitter output and ignores `rxd`, and `txd` is held high. Otherwise `txd` carries the transmitter output.
- R9: With `ctl_open_drain`=0, `txd_oe` is always 1 (push-pull). With `ctl_open_drain`=1, `txd_oe` is 1 only while `txd` is low.
- R10: After reset `txd`=1, `tx_busy`=0, `rx_valid`=0, and with push-pull selected `txd_oe`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit time |
| ctl_frame11 | input | 1 | 0: 10-bit frame, 1: 11-bit frame |
| ctl_par_en | input | 1 | Parity enable |
| ctl_par_odd | input | 1 | 0: even parity, 1: odd parity |
| ctl_idle_long | input | 1 | 0: short idle detect, 1: long idle detect |
| ctl_loop | input | 1 | Loopback request |
| ctl_open_drain | input | 1 | 0: push-pull, 1: open-drain drive style |
| ctl_tx_en | input | 1 | Transmitter enable |
| ctl_rx_en | input | 1 | Receiver enable |
| tx_data | input | 9 | Word to send (upper bits unused in shorter formats) |
| tx_load | input | 1 | Load strobe |
| tx_busy | output | 1 | Frame being sent |
| txd | output | 1 | Serial output |
| txd_oe | output | 1 | Pad drive enable for txd |
| rxd | input | 1 | Serial input |
| rx_data | output | 9 | Received word |
| rx_valid | output | 1 | One-cycle pulse, received word ready |
| rx_par_err | output | 1 | Parity error for the word just received |
| rx_frm_err | output | 1 | Stop bit sampled low |
| idle_det | output | 1 | One-cycle idle-line pulse |

## Verification
The properties assume that `baud_tick` is a single-cycle pulse, and that the control inputs stay constant while a frame is being sent or received. They also assume that `rxd` holds each bit for 16 ticks, as a real line would. The stimulus changes configuration only when both sides are idle. It drives each received bit for exactly 32 clocks, with the tick pulsing every second clock, and spaces frames with idle gaps. The single malformed stop bit is cut short, so that the line recovers before the receiver qualifies a false start.

// File: rtl/sci_pkg.sv
package sci_pkg;
  localparam int unsigned DW   = 9;   // widest data field
  localparam int unsigned MAXF = 11;  // longest frame in bits

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA} rx_state_t;

  // bits in a frame for the selected length
  function automatic logic [3:0] frame_len(input logic f11);
    return f11 ? 4'd11 : 4'd10;
  endfunction

  // data bits: frame minus start, stop and optional parity
  function automatic logic [3:0] data_len(input logic f11, input logic pen);
    return frame_len(f11) - 4'd2 - {3'b000, pen};
  endfunction

  function automatic logic [DW-1:0] data_mask(input logic [3:0] n);
    logic [DW-1:0] m;
    for (int i = 0; i < DW; i++) m[i] = (4'(i) < n);
    return m;
  endfunction

  // parity bit that a correct frame carries
  function automatic logic par_calc(input logic [DW-1:0] d, input logic [3:0] n,
                                    input logic odd);
    return (^(d & data_mask(n))) ^ odd;
  endfunction
endpackage

// File: rtl/sci_tx.sv
module sci_tx
  import sci_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic          f11,
  input  logic          pen,
  input  logic          odd,
  input  logic [DW-1:0] data,
  input  logic          load,
  output logic          busy,
  output logic          line
);
  localparam int CW = $clog2(OSR);

  logic [MAXF-1:0] shreg, frame;
  logic [CW-1:0]   cnt;
  logic [3:0]      bitn, nd, flen;
  logic            act;

  assign nd   = data_len(f11, pen);
  assign flen = frame_len(f11);

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DW; i++)
      if (4'(i) < nd) frame[i+1] = data[i];
    if (pen) frame[nd + 4'd1] = par_calc(data, nd, odd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act   <= 1'b0;
      shreg <= '1;
      cnt   <= '0;
      bitn  <= '0;
    end else if (!act) begin
      if (load && en) begin
        act   <= 1'b1;
        shreg <= frame;
        cnt   <= '0;
        bitn  <= '0;
      end
    end else if (tick) begin
      if (cnt == CW'(OSR - 1)) begin
        cnt   <= '0;
        shreg <= {1'b1, shreg[MAXF-1:1]};
        if (bitn == flen - 4'd1) act <= 1'b0;
        else                     bitn <= bitn + 4'd1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign busy = act;
  assign line = act ? shreg[0] : 1'b1;
endmodule

// File: rtl/sci_rx.sv
module sci_rx
  import sci_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic          f11,
  input  logic          pen,
  input  logic          odd,
  input  logic          line,
  output logic [DW-1:0] data,
  output logic          vld,
  output logic          perr,
  output logic          ferr,
  output logic          stop_seen
);
  localparam int CW = $clog2(OSR);

  rx_state_t     st;
  logic [CW-1:0] cnt;
  logic [3:0]    idx, nd, flen;
  logic [DW:0]   rbuf;

  assign nd   = data_len(f11, pen);
  assign flen = frame_len(f11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RX_IDLE;
      cnt       <= '0;
      idx       <= '0;
      rbuf      <= '0;
      data      <= '0;
      vld       <= 1'b0;
      perr      <= 1'b0;
      ferr      <= 1'b0;
      stop_seen <= 1'b0;
    end else begin
      vld       <= 1'b0;
      stop_seen <= 1'b0;
      if (!en) begin
        st <= RX_IDLE;
      end else if (tick) begin
        case (st)
          RX_IDLE: if (!line) begin
            st  <= RX_START;
            cnt <= '0;
          end
          RX_START: if (cnt == CW'(OSR/2 - 1)) begin
            cnt <= '0;
            idx <= 4'd1;
            st  <= line ? RX_IDLE : RX_DATA;   // false start is dropped
          end else begin
            cnt <= cnt + 1'b1;
          end
          RX_DATA: if (cnt == CW'(OSR - 1)) begin
            cnt <= '0;
            if (idx == flen - 4'd1) begin
              st        <= RX_IDLE;
              vld       <= 1'b1;
              stop_seen <= 1'b1;
              data      <= rbuf[DW-1:0] & data_mask(nd);
              perr      <= pen & (par_calc(rbuf[DW-1:0], nd, odd) ^ rbuf[nd]);
              ferr      <= ~line;
            end else begin
              rbuf[idx - 4'd1] <= line;
              idx              <= idx + 4'd1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sci_idle.sv
module sci_idle
  import sci_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  input  logic long_mode,
  input  logic f11,
  input  logic line,
  input  logic stop_seen,
  output logic det
);
  localparam int IW = $clog2(MAXF * OSR + 1);

  logic [IW-1:0] cnt, thr;
  logic          armed, fired;

  assign thr = IW'(frame_len(f11)) * IW'(OSR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b1;
      fired <= 1'b0;
      det   <= 1'b0;
    end else begin
      det <= 1'b0;
      if (!en) begin
        cnt   <= '0;
        armed <= 1'b1;
        fired <= 1'b0;
      end else begin
        if (stop_seen) armed <= 1'b1;
        if (tick) begin
          if (!line) begin
            cnt   <= '0;
            fired <= 1'b0;
            armed <= 1'b0;
          end else if (!fired && (armed || !long_mode)) begin
            if (cnt == thr - 1'b1) begin
              det   <= 1'b1;
              fired <= 1'b1;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/sci_xcvr.sv
module sci_xcvr
  import sci_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          ctl_frame11,
  input  logic          ctl_par_en,
  input  logic          ctl_par_odd,
  input  logic          ctl_idle_long,
  input  logic          ctl_loop,
  input  logic          ctl_open_drain,
  input  logic          ctl_tx_en,
  input  logic          ctl_rx_en,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_load,
  output logic          tx_busy,
  output logic          txd,
  output logic          txd_oe,
  input  logic          rxd,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          rx_par_err,
  output logic          rx_frm_err,
  output logic          idle_det
);
  // named internal events
  logic tx_line, rx_line, loop_act, stop_seen;

  assign loop_act = ctl_loop & ctl_tx_en & ctl_rx_en;
  assign rx_line  = loop_act ? tx_line : rxd;
  assign txd      = loop_act ? 1'b1 : tx_line;
  assign txd_oe   = ctl_open_drain ? ~txd : 1'b1;

  sci_tx #(.OSR(OSR)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .en(ctl_tx_en),
    .f11(ctl_frame11), .pen(ctl_par_en), .odd(ctl_par_odd),
    .data(tx_data), .load(tx_load), .busy(tx_busy), .line(tx_line)
  );

  sci_rx #(.OSR(OSR)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .en(ctl_rx_en),
    .f11(ctl_frame11), .pen(ctl_par_en), .odd(ctl_par_odd), .line(rx_line),
    .data(rx_data), .vld(rx_valid), .perr(rx_par_err), .ferr(rx_frm_err),
    .stop_seen(stop_seen)
  );

  sci_idle #(.OSR(OSR)) u_idle (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .en(ctl_rx_en),
    .long_mode(ctl_idle_long), .f11(ctl_frame11), .line(rx_line),
    .stop_seen(stop_seen), .det(idle_det)
  );
endmodule

// File: rtl/sci_xcvr_chk.sv
module sci_xcvr_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_load,
  input logic ctl_tx_en,
  input logic ctl_par_en,
  input logic ctl_open_drain,
  input logic tx_busy,
  input logic tx_line,
  input logic loop_act,
  input logic txd,
  input logic txd_oe,
  input logic rx_valid,
  input logic rx_par_err,
  input logic idle_det
);
  // R1
  tx_rest_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_line);

  // R4
  tx_start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(tx_load && ctl_tx_en));

  // R3
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R2
  rx_no_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !ctl_par_en) |-> !rx_par_err);

  // R7
  idle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_det |=> !idle_det);

  // R8
  loop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_act |-> txd);

  // R9
  od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_open_drain && txd) |-> !txd_oe);

  // R9
  pp_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_open_drain |-> txd_oe);
endmodule

bind sci_xcvr sci_xcvr_chk i_chk (
  .clk(clk), .rst_n(rst_n), .tx_load(tx_load), .ctl_tx_en(ctl_tx_en),
  .ctl_par_en(ctl_par_en), .ctl_open_drain(ctl_open_drain), .tx_busy(tx_busy),
  .tx_line(tx_line), .loop_act(loop_act), .txd(txd), .txd_oe(txd_oe),
  .rx_valid(rx_valid), .rx_par_err(rx_par_err), .idle_det(idle_det)
);

// File: tb/test_sci_xcvr.sv
`timescale 1ns/1ps
module test_sci_xcvr;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  logic rst_n = 1'b0, baud_tick = 1'b0;
  logic ctl_frame11 = 0, ctl_par_en = 0, ctl_par_odd = 0, ctl_idle_long = 0;
  logic ctl_loop = 0, ctl_open_drain = 0, ctl_tx_en = 1, ctl_rx_en = 1;
  logic [8:0] tx_data = '0;
  logic tx_load = 0, rxd = 1;
  logic tx_busy, txd, txd_oe, rx_valid, rx_par_err, rx_frm_err, idle_det;
  logic [8:0] rx_data;

  sci_xcvr i_sci_xcvr (.*);

  always @(posedge clk) baud_tick <= rst_n ? ~baud_tick : 1'b0;

  int checks = 0, fails = 0, cyc = 0;
  int rx_cnt = 0, idle_cnt = 0, t_valid = 0, t_idle = 0;
  logic [8:0] got_d; logic got_pe, got_fe;

  always @(negedge clk) begin
    cyc++;
    if (rx_valid) begin
      rx_cnt++; got_d = rx_data; got_pe = rx_par_err; got_fe = rx_frm_err; t_valid = cyc;
    end
    if (idle_det) begin idle_cnt++; t_idle = cyc; end
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected frame bit k, from R1/R2
  function automatic logic fbit(input int k, input logic f11, input logic pen,
                                input logic odd, input logic [8:0] d);
    int nd = (f11 ? 9 : 8) - (pen ? 1 : 0);
    int ones = 0;
    for (int i = 0; i < nd; i++) if (d[i]) ones++;
    if (k == 0) return 1'b0;
    if (k <= nd) return d[k-1];
    if (pen && k == nd + 1) return logic'(ones % 2) ^ odd;
    return 1'b1;
  endfunction

  function automatic logic [8:0] dmask(input logic f11, input logic pen, input logic [8:0] d);
    int nd = (f11 ? 9 : 8) - (pen ? 1 : 0);
    return d & 9'((1 << nd) - 1);
  endfunction

  task automatic send_rx(input logic f11, pen, odd, input logic [8:0] d,
                         input logic bpar, bstop);
    int fb = f11 ? 11 : 10;
    int nd = (f11 ? 9 : 8) - (pen ? 1 : 0);
    for (int k = 0; k < fb; k++) begin
      logic b = fbit(k, f11, pen, odd, d);
      if (pen && bpar && k == nd + 1) b = ~b;
      if (k == fb - 1 && bstop) begin
        rxd = 1'b0; repeat (20) @(negedge clk);
        rxd = 1'b1; repeat (12) @(negedge clk);
      end else begin
        rxd = b; repeat (32) @(negedge clk);
      end
    end
    rxd = 1'b1;
    repeat (64) @(negedge clk);
  endtask

  task automatic load(input logic [8:0] d);
    tx_data = d; tx_load = 1'b1;
    @(negedge clk); tx_load = 1'b0;
  endtask

  task automatic check_tx(input logic [8:0] d);
    int t = 0;
    load(d);
    while (txd && t < 100) begin @(negedge clk); t++; end
    chk(!txd, "R1 start bit", txd, 0);
    repeat (16) @(negedge clk);
    for (int k = 0; k < (ctl_frame11 ? 11 : 10); k++) begin
      logic e = fbit(k, ctl_frame11, ctl_par_en, ctl_par_odd, d);
      chk(txd == e, $sformatf("R1/R2 tx bit %0d", k), txd, e);
      repeat (32) @(negedge clk);
    end
    chk(!tx_busy && txd, "R1 line idle after frame", txd, 1);
  endtask

  // {f11, pen, odd, bad_par, bad_stop, data[8:0]}
  localparam logic [13:0] VEC [8] = '{
    {5'b00000, 9'h0A5}, {5'b01000, 9'h153}, {5'b01100, 9'h07F},
    {5'b10000, 9'h1C3}, {5'b11000, 9'h0E1}, {5'b11110, 9'h05A},
    {5'b01010, 9'h011}, {5'b10001, 9'h155}
  };

  initial begin
    int n0, i0;
    repeat (10) @(negedge clk);
    // R10 reset state
    chk(txd == 1, "R10 txd", txd, 1);
    chk(txd_oe == 1, "R10 txd_oe", txd_oe, 1);
    chk(!tx_busy, "R10 tx_busy", tx_busy, 0);
    chk(!rx_valid, "R10 rx_valid", rx_valid, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    foreach (VEC[v]) begin
      logic [13:0] e = VEC[v];
      ctl_frame11 = e[13]; ctl_par_en = e[12]; ctl_par_odd = e[11];
      n0 = rx_cnt;
      send_rx(e[13], e[12], e[11], e[8:0], e[10], e[9]);
      chk(rx_cnt == n0 + 1, "R3 one rx_valid", rx_cnt - n0, 1);
      chk(got_d == dmask(e[13], e[12], e[8:0]), "R3 rx data", got_d, dmask(e[13], e[12], e[8:0]));
      chk(got_pe == (e[12] & e[10]), "R2 parity err", got_pe, e[12] & e[10]);
      chk(got_fe == e[9], "R3 framing err", got_fe, e[9]);
      if (!e[10] && !e[9]) check_tx(e[8:0]);
    end

    // R4 disabled transmitter ignores load
    ctl_frame11 = 0; ctl_par_en = 0; ctl_par_odd = 0;
    ctl_tx_en = 0; load(9'h000);
    begin
      logic seen_low = 0;
      repeat (100) begin @(negedge clk); if (!txd || tx_busy) seen_low = 1; end
      chk(!seen_low, "R4 load ignored when disabled", seen_low, 0);
    end
    ctl_tx_en = 1;

    // R8 loopback: txd high, rxd ignored
    ctl_loop = 1; rxd = 0; n0 = rx_cnt;
    begin
      logic low = 0;
      load(9'h096);
      repeat (400) begin @(negedge clk); if (!txd) low = 1; end
      chk(!low, "R8 txd held high in loop", low, 0);
    end
    chk(rx_cnt == n0 + 1 && got_d == 9'h096, "R8 loop data", got_d, 9'h096);

    // R4 load while busy ignored (observed through loopback)
    n0 = rx_cnt;
    load(9'h03C); repeat (100) @(negedge clk); load(9'h081);
    repeat (900) @(negedge clk);
    chk(rx_cnt == n0 + 1, "R4 busy load dropped count", rx_cnt - n0, 1);
    chk(got_d == 9'h03C, "R4 first word kept", got_d, 9'h03C);

    // R8 loop without receiver enable: txd carries frame
    ctl_rx_en = 0; rxd = 1;
    begin
      int t = 0;
      load(9'h000);
      while (txd && t < 60) begin @(negedge clk); t++; end
      chk(!txd, "R8 no loop without rx_en", txd, 0);
    end
    repeat (400) @(negedge clk);
    ctl_loop = 0; ctl_rx_en = 1;

    // R9 open drain
    ctl_open_drain = 1; @(negedge clk);
    chk(txd_oe == 0, "R9 released when high", txd_oe, 0);
    begin
      int t = 0;
      load(9'h0F0);
      while (txd && t < 60) begin @(negedge clk); t++; end
      chk(txd_oe == 1, "R9 driven when low", txd_oe, 1);
    end
    repeat (400) @(negedge clk);
    ctl_open_drain = 0;

    // R5 short idle: count starts inside character (data 0xF0, 10-bit no parity)
    ctl_idle_long = 0; repeat (400) @(negedge clk);
    i0 = idle_cnt;
    send_rx(0, 0, 0, 9'h0F0, 0, 0);
    repeat (1000) @(negedge clk);
    chk(idle_cnt == i0 + 1, "R7 single idle pulse short", idle_cnt - i0, 1);
    chk(t_idle - t_valid > 150 && t_idle - t_valid < 220, "R5 short idle gap",
        t_idle - t_valid, 176);

    // R6 long idle: count starts after stop bit
    ctl_idle_long = 1; i0 = idle_cnt;
    send_rx(0, 0, 0, 9'h0F0, 0, 0);
    repeat (1000) @(negedge clk);
    chk(idle_cnt == i0 + 1, "R7 single idle pulse long", idle_cnt - i0, 1);
    chk(t_idle - t_valid > 300 && t_idle - t_valid < 340, "R6 long idle gap",
        t_idle - t_valid, 320);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule